// File: doc/BRIEF.md
# Dependency-Gated Load/Store Sequencer

This block drives the memory traffic of a generated dataflow accelerator. It works through a fixed schedule of loads and stores that is set by parameters. Loads and stores go out on two separate 32-bit master ports. Each port has a cycle/strobe line, byte-lane selects, a linear-burst flag, an address, and an acknowledge input. Stores also have write data, and loads have return data.

Each scheduled access owns one bit of a strobe vector. There is one vector for loads and one for stores, and at most one bit of each is set at a time. Some accesses have no predecessors. Such an access waits for the registered start pulse of the basic block it belongs to. Every other access starts in the cycle in which all of the accesses it waits on complete. When it starts, it takes over the strobe bits of those predecessors.

Load return data is held in one 32-bit result register per load. Store write data follows whichever store currently owns its strobe bit. The slave must acknowledge only while the port's cycle/strobe line is high.

Top module: `dep_mem_sequencer`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output is zero. This covers both cycle/strobe lines, both lane selects, both burst flags, both addresses, the store data and all load results.
- R2: Bit b of `blockGo` starts basic block b. If `blockGo` is high at edge E, each predecessor-free access of that block raises its port's cycle/strobe at edge E+1. Accesses of other blocks do not start.
- R3: An access with predecessors starts at the edge where every predecessor completes in the same cycle. Completion means the predecessor's strobe bit is set and its port's acknowledge is high. Default schedule: load 0 (block 0, byte) and store 0 (block 1, halfword) have no predecessors. Load 1 (word) waits on load 0 and store 0. Store 1 (byte) waits on load 1.
- R4: If the predecessors of an access complete in different cycles, the access never starts.
- R5: A port's cycle/strobe falls at the edge where its access completes, unless another access on the same port starts at that edge. In that case it stays high.
- R6: Lane select at start, with width code 0 = byte, 1 = halfword, 2 = word. A byte access gives 4'b0001 shifted left by address bits [1:0]. A halfword gives 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. A word gives 4'b1111.
- R7: A port's address output takes the starting access's address at the start edge. It holds that value until the next start on that port.
- R8: Store write data updates at every edge while a store strobe bit is set, taking the data input of that store. It therefore shows a store's data one edge after that store starts.
- R9: At the edge where a load completes, its result register takes the load return data. It holds that value through any later edge without that load's completion.
- R10: The linear-burst flag of both ports is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| blockGo | input | NUM_BLOCKS | Per-basic-block start pulse |
| ldAddr | input | NUM_LOADS*ADDR_W | Address of each load, load i at slice i |
| stAddr | input | NUM_STORES*ADDR_W | Address of each store |
| stData | input | NUM_STORES*32 | Write data of each store |
| ldCyc | output | 1 | Load port cycle/strobe |
| ldSel | output | 4 | Load port byte-lane select |
| ldBurst | output | 1 | Load port linear-burst flag |
| ldAdr | output | ADDR_W | Load port address |
| ldDatIn | input | 32 | Load port return data |
| ldAck | input | 1 | Load port acknowledge |
| stCyc | output | 1 | Store port cycle/strobe |
| stSel | output | 4 | Store port byte-lane select |
| stBurst | output | 1 | Store port linear-burst flag |
| stAdr | output | ADDR_W | Store port address |
| stDat | output | 32 | Store port write data |
| stAck | input | 1 | Store port acknowledge |
| ldResult | output | NUM_LOADS*32 | Captured result of each load |

## Verification
A block start pulse shows up on the port two edges later: one edge registers the pulse and the next raises cycle/strobe, address and lanes. A completion has its effects at the same edge that samples the acknowledge. At that edge the result is captured, the port releases, and any dependent access starts. Store data lags the start of its store by exactly one more edge. The bench drives every stimulus just after a falling edge and samples one falling edge after the counted number of rising edges. It sweeps the low address bits of all four accesses, and it runs a separate pass in which the two predecessors of load 1 complete in different cycles.

// File: rtl/depseq_pkg.sv
package depseq_pkg;

  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    AW_BYTE = 2'd0,
    AW_HALF = 2'd1,
    AW_WORD = 2'd2
  } accWidth_e;

  // Per-port command from control to datapath.
  typedef struct packed {
    logic issue;   // some access of this port starts this cycle
    logic retire;  // some access of this port completes this cycle
  } portCmd_t;

  function automatic logic [LANES-1:0] laneSel(input logic [1:0] w, input logic [1:0] lo);
    logic [LANES-1:0] r;
    case (accWidth_e'(w))
      AW_BYTE: r = 4'b0001 << lo;
      AW_HALF: r = lo[1] ? 4'b1100 : 4'b0011;
      default: r = 4'b1111;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/depseq_ctrl.sv
module depseq_ctrl
  import depseq_pkg::*;
#(
  parameter int NL = 2,
  parameter int NS = 2,
  parameter int NB = 2,
  parameter int BW = 1,
  parameter logic [NL*BW-1:0] LD_BLOCK  = '0,
  parameter logic [NS*BW-1:0] ST_BLOCK  = '0,
  parameter logic [NL*NL-1:0] LD_DEP_LD = '0,
  parameter logic [NL*NS-1:0] LD_DEP_ST = '0,
  parameter logic [NS*NL-1:0] ST_DEP_LD = '0,
  parameter logic [NS*NS-1:0] ST_DEP_ST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] blockGo,
  input  logic          ldAck,
  input  logic          stAck,
  output logic [NL-1:0] ldGo,
  output logic [NL-1:0] ldEnd,
  output logic [NS-1:0] stGo,
  output logic [NS-1:0] stStb,
  output portCmd_t      ldCmd,
  output portCmd_t      stCmd
);

  // Accesses that some other access waits on; the rest release on completion.
  function automatic logic [NL-1:0] ldUsedMask();
    logic [NL-1:0] m;
    m = '0;
    for (int j = 0; j < NL; j++) begin
      for (int i = 0; i < NL; i++) if (LD_DEP_LD[i*NL+j]) m[j] = 1'b1;
      for (int k = 0; k < NS; k++) if (ST_DEP_LD[k*NL+j]) m[j] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [NS-1:0] stUsedMask();
    logic [NS-1:0] m;
    m = '0;
    for (int j = 0; j < NS; j++) begin
      for (int i = 0; i < NL; i++) if (LD_DEP_ST[i*NS+j]) m[j] = 1'b1;
      for (int k = 0; k < NS; k++) if (ST_DEP_ST[k*NS+j]) m[j] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [NL-1:0] LD_USED = ldUsedMask();
  localparam logic [NS-1:0] ST_USED = stUsedMask();

  logic [NB-1:0] bbStartR;
  logic [NL-1:0] ldStb, ldNext;
  logic [NS-1:0] stEnd, stNext;

  assign ldEnd = ldStb & {NL{ldAck}};
  assign stEnd = stStb & {NS{stAck}};

  for (genvar i = 0; i < NL; i++) begin : g_ld
    localparam logic [NL-1:0] DL = LD_DEP_LD[i*NL +: NL];
    localparam logic [NS-1:0] DS = LD_DEP_ST[i*NS +: NS];
    localparam int BLK = int'(LD_BLOCK[i*BW +: BW]);
    if (DL != '0 || DS != '0) begin : g_dep
      assign ldGo[i] = (&(ldEnd | ~DL)) & (&(stEnd | ~DS));
      p_dep_gate_r4 : assert property (@(posedge clk) disable iff (rst)
        $rose(ldStb[i]) |-> $past((&(ldEnd | ~DL)) && (&(stEnd | ~DS))));
    end else begin : g_root
      assign ldGo[i] = bbStartR[BLK];
    end
  end

  for (genvar i = 0; i < NS; i++) begin : g_st
    localparam logic [NL-1:0] DL = ST_DEP_LD[i*NL +: NL];
    localparam logic [NS-1:0] DS = ST_DEP_ST[i*NS +: NS];
    localparam int BLK = int'(ST_BLOCK[i*BW +: BW]);
    if (DL != '0 || DS != '0) begin : g_dep
      assign stGo[i] = (&(ldEnd | ~DL)) & (&(stEnd | ~DS));
      p_dep_gate_r3 : assert property (@(posedge clk) disable iff (rst)
        $rose(stStb[i]) |-> $past((&(ldEnd | ~DL)) && (&(stEnd | ~DS))));
    end else begin : g_root
      assign stGo[i] = bbStartR[BLK];
    end
  end

  always_comb begin
    ldNext = ldStb & ~(ldEnd & ~LD_USED);
    stNext = stStb & ~(stEnd & ~ST_USED);
    for (int i = 0; i < NL; i++) begin
      if (ldGo[i]) begin
        ldNext = ldNext & ~LD_DEP_LD[i*NL +: NL];
        stNext = stNext & ~LD_DEP_ST[i*NS +: NS];
      end
    end
    for (int i = 0; i < NS; i++) begin
      if (stGo[i]) begin
        ldNext = ldNext & ~ST_DEP_LD[i*NL +: NL];
        stNext = stNext & ~ST_DEP_ST[i*NS +: NS];
      end
    end
    ldNext = ldNext | ldGo;
    stNext = stNext | stGo;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bbStartR <= '0;
      ldStb    <= '0;
      stStb    <= '0;
    end else begin
      bbStartR <= blockGo;
      ldStb    <= ldNext;
      stStb    <= stNext;
    end
  end

  assign ldCmd.issue  = |ldGo;
  assign ldCmd.retire = |ldEnd;
  assign stCmd.issue  = |stGo;
  assign stCmd.retire = |stEnd;

  // Handing strobes from predecessors keeps each vector zero-or-one-hot (R3).
  p_ld_onehot_r3 : assert property (@(posedge clk) disable iff (rst) $onehot0(ldStb));
  p_st_onehot_r3 : assert property (@(posedge clk) disable iff (rst) $onehot0(stStb));
  p_block_pulse_r2 : assert property (@(posedge clk) disable iff (rst)
    ($past(blockGo) != '0) |-> (bbStartR == $past(blockGo)));

endmodule

// File: rtl/depseq_port.sv
module depseq_port
  import depseq_pkg::*;
#(
  parameter int N      = 2,
  parameter int ADDR_W = 32,
  parameter logic [N*2-1:0] WIDTHS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  portCmd_t          cmd,
  input  logic [N-1:0]      go,
  input  logic [N*ADDR_W-1:0] addrs,
  output logic              cyc,
  output logic [LANES-1:0]  sel,
  output logic              burst,
  output logic [ADDR_W-1:0] adr
);

  logic [ADDR_W-1:0] pickAdr;
  logic [LANES-1:0]  pickSel;

  // Lowest-numbered starting access wins if a schedule ever starts two.
  always_comb begin
    pickAdr = '0;
    pickSel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (go[i]) begin
        pickAdr = addrs[i*ADDR_W +: ADDR_W];
        pickSel = laneSel(WIDTHS[i*2 +: 2], addrs[i*ADDR_W +: 2]);
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cyc   <= 1'b0;
      sel   <= '0;
      burst <= 1'b0;
      adr   <= '0;
    end else if (cmd.issue) begin
      cyc   <= 1'b1;
      sel   <= pickSel;
      burst <= 1'b0;
      adr   <= pickAdr;
    end else if (cmd.retire) begin
      cyc   <= 1'b0;
    end
  end

  p_issue_raises_r2 : assert property (@(posedge clk) disable iff (rst) cmd.issue |=> cyc);
  p_retire_drops_r5 : assert property (@(posedge clk) disable iff (rst)
    (cmd.retire && !cmd.issue) |=> !cyc);
  p_lanes_legal_r6 : assert property (@(posedge clk) disable iff (rst)
    cyc |-> (sel inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111}));
  p_adr_hold_r7 : assert property (@(posedge clk) disable iff (rst)
    !cmd.issue |=> $stable(adr) && $stable(sel));
  p_no_burst_r10 : assert property (@(posedge clk) disable iff (rst) !burst);

endmodule

// File: rtl/depseq_dpath.sv
module depseq_dpath
  import depseq_pkg::*;
#(
  parameter int NL     = 2,
  parameter int NS     = 2,
  parameter int ADDR_W = 32,
  parameter logic [NL*2-1:0] LD_WIDTH = '0,
  parameter logic [NS*2-1:0] ST_WIDTH = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  portCmd_t             ldCmd,
  input  portCmd_t             stCmd,
  input  logic [NL-1:0]        ldGo,
  input  logic [NL-1:0]        ldEnd,
  input  logic [NS-1:0]        stGo,
  input  logic [NS-1:0]        stStb,
  input  logic [NL*ADDR_W-1:0] ldAddr,
  input  logic [NS*ADDR_W-1:0] stAddr,
  input  logic [NS*BUS_W-1:0]  stData,
  input  logic [BUS_W-1:0]     ldDatIn,
  output logic                 ldCyc,
  output logic [LANES-1:0]     ldSel,
  output logic                 ldBurst,
  output logic [ADDR_W-1:0]    ldAdr,
  output logic                 stCyc,
  output logic [LANES-1:0]     stSel,
  output logic                 stBurst,
  output logic [ADDR_W-1:0]    stAdr,
  output logic [BUS_W-1:0]     stDat,
  output logic [NL*BUS_W-1:0]  ldResult
);

  depseq_port #(.N(NL), .ADDR_W(ADDR_W), .WIDTHS(LD_WIDTH)) u_ldPort (
    .clk(clk), .rst(rst), .cmd(ldCmd), .go(ldGo), .addrs(ldAddr),
    .cyc(ldCyc), .sel(ldSel), .burst(ldBurst), .adr(ldAdr)
  );

  depseq_port #(.N(NS), .ADDR_W(ADDR_W), .WIDTHS(ST_WIDTH)) u_stPort (
    .clk(clk), .rst(rst), .cmd(stCmd), .go(stGo), .addrs(stAddr),
    .cyc(stCyc), .sel(stSel), .burst(stBurst), .adr(stAdr)
  );

  logic [BUS_W-1:0] pickDat;

  always_comb begin
    pickDat = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (stStb[i]) pickDat = stData[i*BUS_W +: BUS_W];
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)         stDat <= '0;
    else if (|stStb) stDat <= pickDat;
  end

  p_stdat_follow_r8 : assert property (@(posedge clk) disable iff (rst)
    (stStb == '0) |=> $stable(stDat));

  for (genvar i = 0; i < NL; i++) begin : g_res
    always_ff @(posedge clk or posedge rst) begin
      if (rst)           ldResult[i*BUS_W +: BUS_W] <= '0;
      else if (ldEnd[i]) ldResult[i*BUS_W +: BUS_W] <= ldDatIn;
    end

    p_capture_r9 : assert property (@(posedge clk) disable iff (rst)
      ldEnd[i] |=> (ldResult[i*BUS_W +: BUS_W] == $past(ldDatIn)));
    p_result_hold_r9 : assert property (@(posedge clk) disable iff (rst)
      !ldEnd[i] |=> $stable(ldResult[i*BUS_W +: BUS_W]));
  end

endmodule

// File: rtl/dep_mem_sequencer.sv
module dep_mem_sequencer
  import depseq_pkg::*;
#(
  parameter int NUM_LOADS  = 2,
  parameter int NUM_STORES = 2,
  parameter int NUM_BLOCKS = 2,
  parameter int ADDR_W     = 32,
  // Block index per access, BW bits each, access i at slice i.
  parameter logic [NUM_LOADS-1:0]  LD_BLOCK = 2'b00,
  parameter logic [NUM_STORES-1:0] ST_BLOCK = 2'b01,
  // Width code per access: 0 byte, 1 halfword, 2 word.
  parameter logic [NUM_LOADS*2-1:0]  LD_WIDTH = 4'b1000,
  parameter logic [NUM_STORES*2-1:0] ST_WIDTH = 4'b0001,
  // Row i, bit j set: access i waits on access j of the named kind.
  parameter logic [NUM_LOADS*NUM_LOADS-1:0]   LD_DEP_LD = 4'b0100,
  parameter logic [NUM_LOADS*NUM_STORES-1:0]  LD_DEP_ST = 4'b0100,
  parameter logic [NUM_STORES*NUM_LOADS-1:0]  ST_DEP_LD = 4'b1000,
  parameter logic [NUM_STORES*NUM_STORES-1:0] ST_DEP_ST = 4'b0000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BLOCKS-1:0]       blockGo,
  input  logic [NUM_LOADS*ADDR_W-1:0] ldAddr,
  input  logic [NUM_STORES*ADDR_W-1:0] stAddr,
  input  logic [NUM_STORES*32-1:0]    stData,
  output logic                        ldCyc,
  output logic [3:0]                  ldSel,
  output logic                        ldBurst,
  output logic [ADDR_W-1:0]           ldAdr,
  input  logic [31:0]                 ldDatIn,
  input  logic                        ldAck,
  output logic                        stCyc,
  output logic [3:0]                  stSel,
  output logic                        stBurst,
  output logic [ADDR_W-1:0]           stAdr,
  output logic [31:0]                 stDat,
  input  logic                        stAck,
  output logic [NUM_LOADS*32-1:0]     ldResult
);

  localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

  logic [NUM_LOADS-1:0]  ldGo, ldEnd;
  logic [NUM_STORES-1:0] stGo, stStb;
  portCmd_t ldCmd, stCmd;

  depseq_ctrl #(
    .NL(NUM_LOADS), .NS(NUM_STORES), .NB(NUM_BLOCKS), .BW(BW),
    .LD_BLOCK(LD_BLOCK), .ST_BLOCK(ST_BLOCK),
    .LD_DEP_LD(LD_DEP_LD), .LD_DEP_ST(LD_DEP_ST),
    .ST_DEP_LD(ST_DEP_LD), .ST_DEP_ST(ST_DEP_ST)
  ) u_ctrl (
    .clk(clk), .rst(rst), .blockGo(blockGo), .ldAck(ldAck), .stAck(stAck),
    .ldGo(ldGo), .ldEnd(ldEnd), .stGo(stGo), .stStb(stStb),
    .ldCmd(ldCmd), .stCmd(stCmd)
  );

  depseq_dpath #(
    .NL(NUM_LOADS), .NS(NUM_STORES), .ADDR_W(ADDR_W),
    .LD_WIDTH(LD_WIDTH), .ST_WIDTH(ST_WIDTH)
  ) u_dpath (
    .clk(clk), .rst(rst), .ldCmd(ldCmd), .stCmd(stCmd),
    .ldGo(ldGo), .ldEnd(ldEnd), .stGo(stGo), .stStb(stStb),
    .ldAddr(ldAddr), .stAddr(stAddr), .stData(stData), .ldDatIn(ldDatIn),
    .ldCyc(ldCyc), .ldSel(ldSel), .ldBurst(ldBurst), .ldAdr(ldAdr),
    .stCyc(stCyc), .stSel(stSel), .stBurst(stBurst), .stAdr(stAdr),
    .stDat(stDat), .ldResult(ldResult)
  );

endmodule

// File: tb/sim_dep_mem_sequencer.sv
module sim_dep_mem_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  blockGo = '0;
  logic [63:0] ldAddr = '0;
  logic [63:0] stAddr = '0;
  logic [63:0] stData = '0;
  logic [31:0] ldDatIn = '0;
  logic        ldAck = 1'b0;
  logic        stAck = 1'b0;
  logic        ldCyc, ldBurst, stCyc, stBurst;
  logic [3:0]  ldSel, stSel;
  logic [31:0] ldAdr, stAdr, stDat;
  logic [63:0] ldResult;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dep_mem_sequencer u0 (
    .clk(clk), .rst(rst), .blockGo(blockGo), .ldAddr(ldAddr), .stAddr(stAddr),
    .stData(stData), .ldCyc(ldCyc), .ldSel(ldSel), .ldBurst(ldBurst), .ldAdr(ldAdr),
    .ldDatIn(ldDatIn), .ldAck(ldAck), .stCyc(stCyc), .stSel(stSel), .stBurst(stBurst),
    .stAdr(stAdr), .stDat(stDat), .stAck(stAck), .ldResult(ldResult)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [3:0] byteLanes(input logic [31:0] a);
    return 4'(1 << a[1:0]);
  endfunction

  function automatic logic [3:0] halfLanes(input logic [31:0] a);
    return a[1] ? 4'b1100 : 4'b0011;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] l0a, l1a, s0a, s1a, d0, d1, s0d, s1d;
    step();
    step();
    // R1: reset state
    chk("R1", "ldCyc", ldCyc, 0);   chk("R1", "stCyc", stCyc, 0);
    chk("R1", "ldSel", ldSel, 0);   chk("R1", "stSel", stSel, 0);
    chk("R1", "ldAdr", ldAdr, 0);   chk("R1", "stAdr", stAdr, 0);
    chk("R1", "stDat", stDat, 0);   chk("R1", "ldResult", ldResult, 0);
    chk("R1", "bursts", {ldBurst, stBurst}, 0);
    rst = 1'b0;
    step();
    chk("R1", "ldCyc after reset", ldCyc, 0);
    chk("R1", "stCyc after reset", stCyc, 0);

    // R2 and R4: predecessors of load 1 complete in different cycles
    ldAddr = {32'h3000_0000, 32'h1000_0002};
    stAddr = {32'h4000_0001, 32'h2000_0002};
    stData = {32'h1111_2222, 32'h3333_4444};
    blockGo = 2'b01; step(); blockGo = 2'b00; step();
    chk("R2", "block0 starts load0", ldCyc, 1);
    chk("R2", "block0 leaves store port idle", stCyc, 0);
    chk("R6", "byte lanes load0", ldSel, 4'b0100);
    ldDatIn = 32'hDEAD_0001; ldAck = 1'b1; step(); ldAck = 1'b0;
    chk("R4", "load1 not started by load0 alone", ldCyc, 0);
    chk("R9", "load0 result", ldResult[31:0], 32'hDEAD_0001);
    blockGo = 2'b10; step(); blockGo = 2'b00; step();
    chk("R2", "block1 starts store0", stCyc, 1);
    chk("R2", "block1 leaves load port idle", ldCyc, 0);
    chk("R6", "half lanes store0", stSel, 4'b1100);
    stAck = 1'b1; step(); stAck = 1'b0;
    chk("R4", "load1 not started after split completions", ldCyc, 0);
    chk("R5", "store port released", stCyc, 0);
    repeat (3) step();
    chk("R4", "load1 still idle", ldCyc, 0);

    // Sweep of low address bits over the full schedule
    for (int n = 0; n < 16; n++) begin
      l0a = 32'h1000_0000 + 32'(n * 8) + 32'(n % 4);
      s0a = 32'h2000_0000 + 32'(n * 16) + 32'((n / 4) % 4);
      l1a = 32'h3000_0000 + 32'(n * 4);
      s1a = 32'h4000_0000 + 32'(n * 32) + 32'((n * 3) % 4);
      d0  = 32'hA500_0000 + 32'(n) * 32'h0001_0203;
      d1  = ~d0 ^ 32'(n);
      s0d = 32'h5A5A_0000 | 32'(n);
      s1d = 32'h00C3_0000 | 32'(n * 257);
      ldAddr = {l1a, l0a};
      stAddr = {s1a, s0a};
      stData = {s1d, s0d};

      blockGo = 2'b11; step(); blockGo = 2'b00; step();
      chk("R2", "load0 started", ldCyc, 1);
      chk("R2", "store0 started", stCyc, 1);
      chk("R6", "byte lanes load0", ldSel, byteLanes(l0a));
      chk("R6", "half lanes store0", stSel, halfLanes(s0a));
      chk("R7", "load0 address", ldAdr, l0a);
      chk("R7", "store0 address", stAdr, s0a);
      step();
      chk("R8", "store0 data", stDat, s0d);
      chk("R10", "burst flags", {ldBurst, stBurst}, 0);

      ldDatIn = d0; ldAck = 1'b1; stAck = 1'b1; step();
      ldAck = 1'b0; stAck = 1'b0; ldDatIn = 32'hFFFF_0000 ^ d0;
      chk("R3", "load1 started on joint completion", ldCyc, 1);
      chk("R6", "word lanes load1", ldSel, 4'b1111);
      chk("R7", "load1 address", ldAdr, l1a);
      chk("R5", "store port released", stCyc, 0);
      chk("R9", "load0 result", ldResult[31:0], d0);
      step(); step();
      chk("R9", "load0 result held", ldResult[31:0], d0);
      chk("R7", "load1 address held", ldAdr, l1a);

      ldDatIn = d1; ldAck = 1'b1; step(); ldAck = 1'b0;
      chk("R5", "load port released", ldCyc, 0);
      chk("R3", "store1 started after load1", stCyc, 1);
      chk("R6", "byte lanes store1", stSel, byteLanes(s1a));
      chk("R7", "store1 address", stAdr, s1a);
      chk("R9", "load1 result", ldResult[63:32], d1);
      step();
      chk("R8", "store1 data", stDat, s1d);
      stAck = 1'b1; step(); stAck = 1'b0;
      chk("R5", "store port released after store1", stCyc, 0);
      step();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule